// File: doc/BRIEF.md
# Dual-Direction Computed Byte Substitution Unit

This block performs the byte substitution step of a 128-bit block cipher round in either direction. It has no lookup table. It computes each result from a multiplicative inverse in GF(2^8) and a bitwise affine transform over that field. One mode bit selects the direction, and both directions share the same field inverter.

In forward mode the input byte is inverted in the field first. The affine transform with constant 0x63 is then applied to the result. In inverse mode the inverse affine transform with constant 0x05 is applied first, and the result is then inverted in the field. The unit is purely combinational: the output follows the input and the mode within the same cycle. It is meant to sit inside a round datapath that supplies the registers around it.

Top module: `sbox_dual`

## Requirements
- R1: The forward affine transform sets output bit m (bit 7 = MSB) to the XOR of input bits m, (m+4)%8, (m+5)%8, (m+6)%8, (m+7)%8 and bit m of the constant 0x63.
- R2: The inverse affine transform sets output bit m to the XOR of input bits (m+2)%8, (m+5)%8, (m+7)%8 and bit m of the constant 0x05.
- R3: The field inverse is taken modulo x^8+x^4+x^3+x+1 (0x11B): for every nonzero x, x times inv(x) equals 0x01, and inv(0x00) is 0x00.
- R4: With sub_mode_i = 0 (forward), data_o equals the forward affine transform of inv(data_i).
- R5: With sub_mode_i = 1 (inverse), data_o equals inv(inverse affine transform of data_i).
- R6: The zero corner gives forward(0x00) = 0x63, inverse(0x63) = 0x00 and inverse(0x00) = 0x52.
- R7: Known points hold: forward(0x53) = 0xED, forward(0x01) = 0x7C, forward(0xFF) = 0x16, inverse(0xED) = 0x53.
- R8: For all 256 bytes x, inverse(forward(x)) = x and forward(inverse(x)) = x.
- R9: The forward mapping has no fixed point and no complemented fixed point: forward(x) differs from both x and ~x for every x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_mode_i | input | 1 | Direction select: 0 = forward substitution, 1 = inverse substitution |
| data_i | input | 8 | Byte to substitute |
| data_o | output | 8 | Substituted byte |

## Verification
Zero is the main corner case. An inverter built from exponentiation maps 0 to 0 with no extra logic, but a design that handled 0 as a special case the wrong way would return 0x00 or 0x01 from forward(0) instead of 0x63. Swapping the order of affine and inversion in either mode gives wrong values across almost the whole byte range. The full 256-byte round trip in both directions exposes that, as well as any mistaken bit rotation in either affine equation or a wrong affine constant. Fixed known points, together with the check for fixed points and complemented fixed points, catch a wrong reduction polynomial. Such an error would still be self-consistent in the round trip.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        SUB_FWD = 1'b0,
        SUB_INV = 1'b1
    } sub_mode_e;

    // Multiply in GF(2^8); red_lo is the reduction polynomial without its x^8 term.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b, input byte_t red_lo);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[BYTE_W-1] ? ((sh << 1) ^ red_lo) : (sh << 1);
        end
        return acc;
    endfunction

    // Inverse affine map, used only by checks in the forward variant.
    function automatic byte_t aff_back(input byte_t x, input byte_t c);
        byte_t y;
        for (int m = 0; m < BYTE_W; m++)
            y[m] = x[(m+2)%BYTE_W] ^ x[(m+5)%BYTE_W] ^ x[(m+7)%BYTE_W] ^ c[m];
        return y;
    endfunction

    // Forward affine map, used only by checks in the inverse variant.
    function automatic byte_t aff_fore(input byte_t x, input byte_t c);
        byte_t y;
        for (int m = 0; m < BYTE_W; m++)
            y[m] = x[m] ^ x[(m+4)%BYTE_W] ^ x[(m+5)%BYTE_W]
                 ^ x[(m+6)%BYTE_W] ^ x[(m+7)%BYTE_W] ^ c[m];
        return y;
    endfunction

endpackage

// File: rtl/sbox_gf_inv.sv
module sbox_gf_inv
    import sbox_pkg::*;
#(
    parameter byte_t RED_LO = 8'h1B
) (
    input  byte_t val_i,
    output byte_t inv_o
);
    localparam int unsigned STEPS = BYTE_W - 1;

    // pow_sq[i] = x^(2^i); prod[i] = x^(2+4+...+2^i); prod[STEPS] = x^254
    byte_t pow_sq [0:STEPS];
    byte_t prod   [1:STEPS];

    assign pow_sq[0] = val_i;

    for (genvar i = 1; i <= STEPS; i++) begin : g_square
        assign pow_sq[i] = gf_mul(pow_sq[i-1], pow_sq[i-1], RED_LO);
    end

    assign prod[1] = pow_sq[1];

    for (genvar i = 2; i <= STEPS; i++) begin : g_accum
        assign prod[i] = gf_mul(prod[i-1], pow_sq[i], RED_LO);
    end

    assign inv_o = prod[STEPS];

    always_comb begin
        if (!$isunknown(val_i) && !$isunknown(inv_o)) begin
            // R3
            inv_product_chk: assert (val_i == '0 || gf_mul(val_i, inv_o, RED_LO) == 8'h01)
                else $error("field inverse product is not one");
            // R3
            inv_zero_chk: assert ((val_i == '0) == (inv_o == '0))
                else $error("zero handling of field inverse broken");
        end
    end

endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
    import sbox_pkg::*;
#(
    parameter bit    BACKWARD = 1'b0,
    parameter byte_t CONST    = 8'h63
) (
    input  byte_t x_i,
    output byte_t y_o
);

    if (!BACKWARD) begin : g_fore
        for (genvar m = 0; m < BYTE_W; m++) begin : g_bit
            assign y_o[m] = x_i[m] ^ x_i[(m+4)%BYTE_W] ^ x_i[(m+5)%BYTE_W]
                          ^ x_i[(m+6)%BYTE_W] ^ x_i[(m+7)%BYTE_W] ^ CONST[m];
        end

        always_comb begin
            if (!$isunknown(x_i) && !$isunknown(y_o)) begin
                // R1
                fore_undo_chk: assert (aff_back(y_o, 8'h05) == x_i)
                    else $error("forward affine not undone by inverse affine");
            end
        end
    end else begin : g_back
        for (genvar m = 0; m < BYTE_W; m++) begin : g_bit
            assign y_o[m] = x_i[(m+2)%BYTE_W] ^ x_i[(m+5)%BYTE_W]
                          ^ x_i[(m+7)%BYTE_W] ^ CONST[m];
        end

        always_comb begin
            if (!$isunknown(x_i) && !$isunknown(y_o)) begin
                // R2
                back_undo_chk: assert (aff_fore(y_o, 8'h63) == x_i)
                    else $error("inverse affine not undone by forward affine");
            end
        end
    end

endmodule

// File: rtl/sbox_dual.sv
module sbox_dual
    import sbox_pkg::*;
#(
    parameter byte_t RED_LO    = 8'h1B,
    parameter byte_t FWD_CONST = 8'h63,
    parameter byte_t INV_CONST = 8'h05
) (
    input  logic       sub_mode_i,
    input  logic [7:0] data_i,
    output logic [7:0] data_o
);
    sub_mode_e mode;
    byte_t     pre_aff;
    byte_t     inv_in;
    byte_t     inv_out;
    byte_t     post_aff;

    assign mode = sub_mode_e'(sub_mode_i);

    sbox_affine #(.BACKWARD(1'b1), .CONST(INV_CONST)) u_pre (
        .x_i (data_i),
        .y_o (pre_aff)
    );

    // Single inverter shared by both directions
    assign inv_in = (mode == SUB_INV) ? pre_aff : data_i;

    sbox_gf_inv #(.RED_LO(RED_LO)) u_inv (
        .val_i (inv_in),
        .inv_o (inv_out)
    );

    sbox_affine #(.BACKWARD(1'b0), .CONST(FWD_CONST)) u_post (
        .x_i (inv_out),
        .y_o (post_aff)
    );

    assign data_o = (mode == SUB_INV) ? inv_out : post_aff;

    always_comb begin
        if (!$isunknown(data_i) && !$isunknown(sub_mode_i) && !$isunknown(data_o)) begin
            // R9
            no_fixed_point_chk: assert (mode == SUB_INV || (data_o != data_i && data_o != ~data_i))
                else $error("forward substitution hit a fixed point");
        end
    end

endmodule

// File: tb/sbox_dual_tb.sv
`timescale 1ns/1ps
module sbox_dual_tb;

    logic       clk;
    logic       rst_n;
    logic       sub_mode_i;
    logic [7:0] data_i;
    logic [7:0] data_o;

    int unsigned n_vec;
    int unsigned n_bad;
    logic        done;

    sbox_dual u_dut (
        .sub_mode_i (sub_mode_i),
        .data_i     (data_i),
        .data_o     (data_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [7:0] r_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] s;
        p = 8'h00;
        s = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p ^= s;
            s = s[7] ? ((s << 1) ^ 8'h1B) : (s << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] r_inv(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int c = 1; c < 256; c++)
            if (a != 8'h00 && r_mul(a, 8'(c)) == 8'h01) r = 8'(c);
        return r;
    endfunction

    function automatic logic [7:0] r_aff(input logic [7:0] x);
        logic [7:0] y;
        for (int m = 0; m < 8; m++)
            y[m] = x[m] ^ x[(m+4)%8] ^ x[(m+5)%8] ^ x[(m+6)%8] ^ x[(m+7)%8] ^ (8'h63 >> m) & 1'b1;
        return y;
    endfunction

    function automatic logic [7:0] r_aff_back(input logic [7:0] x);
        logic [7:0] y;
        for (int m = 0; m < 8; m++)
            y[m] = x[(m+2)%8] ^ x[(m+5)%8] ^ x[(m+7)%8] ^ (8'h05 >> m) & 1'b1;
        return y;
    endfunction

    function automatic logic [7:0] r_fwd(input logic [7:0] x);
        return r_aff(r_inv(x));
    endfunction

    function automatic logic [7:0] r_bwd(input logic [7:0] x);
        return r_inv(r_aff_back(x));
    endfunction

    task automatic apply(input logic mode, input logic [7:0] x, output logic [7:0] y);
        @(posedge clk);
        #0.5;
        sub_mode_i = mode;
        data_i     = x;
        @(negedge clk);
        y = data_o;
    endtask

    task automatic check(input string req, input logic mode, input logic [7:0] x,
                         input logic [7:0] expv);
        logic [7:0] got;
        apply(mode, x, got);
        n_vec++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s mode=%0d in=%02h got=%02h exp=%02h", req, mode, x, got, expv);
        end
    endtask

    initial begin
        done = 1'b0;
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung got=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] t1;
        logic [7:0] t2;
        n_vec      = 0;
        n_bad      = 0;
        rst_n      = 1'b0;
        sub_mode_i = 1'b0;
        data_i     = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R6: the output for the idle input is defined right after reset
        check("R6", 1'b0, 8'h00, 8'h63);
        check("R6", 1'b1, 8'h63, 8'h00);
        check("R6", 1'b1, 8'h00, 8'h52);

        // R7 known points
        check("R7", 1'b0, 8'h53, 8'hED);
        check("R7", 1'b0, 8'h01, 8'h7C);
        check("R7", 1'b0, 8'hFF, 8'h16);
        check("R7", 1'b1, 8'hED, 8'h53);

        // R1 R3 R4: full forward sweep against the bench model
        for (int v = 0; v < 256; v++) check("R4", 1'b0, 8'(v), r_fwd(8'(v)));
        // R2 R5: full inverse sweep
        for (int v = 0; v < 256; v++) check("R5", 1'b1, 8'(v), r_bwd(8'(v)));

        // R8 round trips through the device in both orders
        for (int v = 0; v < 256; v++) begin
            apply(1'b0, 8'(v), t1);
            check("R8", 1'b1, t1, 8'(v));
            apply(1'b1, 8'(v), t2);
            check("R8", 1'b0, t2, 8'(v));
        end

        // R9 no fixed or complemented fixed point in forward mode
        for (int v = 0; v < 256; v++) begin
            apply(1'b0, 8'(v), t1);
            n_vec++;
            if (t1 == 8'(v) || t1 == ~8'(v)) begin
                n_bad++;
                $display("FAIL R9 in=%02h got=%02h exp=not %02h/%02h", v, t1, v, ~8'(v));
            end
        end

        // R4 R5 random mixed-mode traffic, fixed seed
        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'h5B0C_0DE1);
        end
        for (int n = 0; n < 400; n++) begin
            logic       md;
            logic [7:0] xv;
            md = 1'($urandom());
            xv = 8'($urandom());
            check(md ? "R5" : "R4", md, xv, md ? r_bwd(xv) : r_fwd(xv));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule